// File: doc/BRIEF.md
# Locked-Access Wait-State Memory Controller

This controller sits between a processor bus and a memory that a second bus master may also request. The processor presents an address, a two-bit cycle type, a write flag and a lock flag one cycle ahead of the data cycle. The controller stretches that data cycle with an active-low wait output. It runs an address check only when the cycle type is non-sequential. It raises an abort when that check fails. It drives a one-cycle memory strobe when the access goes ahead.

The second master asks for the memory with a request line. It receives a grant only at an access boundary, and never while the processor holds its lock flag high. A swap (a locked read followed by a locked write to the same location) therefore reaches memory as one unbroken pair. The wait output is updated on the falling clock edge, so it moves only in the low phase and stretches that phase. No limit applies to how long it stays low.

The central state machine has four states:

- `ST_IDLE` is the access boundary.
- `ST_XLATE` is the single translation cycle.
- `ST_STALL` covers the remaining DRAM wait states.
- `ST_EXT` means the other master owns the memory.

The transitions are:

- DISPATCH_N: IDLE or EXT to XLATE.
- DISPATCH_S: IDLE or EXT to IDLE, with a strobe.
- GRANT: IDLE to EXT.
- RELEASE: EXT to IDLE or XLATE, through dispatch.
- FAULT: XLATE to IDLE, with abort.
- SHORT: XLATE to IDLE, used when the wait count is 1.
- LONG: XLATE to STALL.
- FINISH: STALL to IDLE, with a strobe.

Top module: `lockwait_memctl`

## Requirements
- R1: While reset is held, and until the first access, `nwait_n` is 1 and `abort`, `ext_gnt` and `mem_en` are 0.
- R2: A non-sequential cycle (`cyc_type` 2'b10) whose address is at or below `XLATE_LIMIT` sees exactly `N_WAIT` wait cycles (default 2). In the completing cycle, `mem_en` is 1, `mem_we` equals the presented write flag and `mem_addr` equals the presented address.
- R3: A sequential cycle (`cyc_type` 2'b01) sees zero wait cycles and gets `mem_en` in its data cycle. It is not translated, so an address above the limit raises no abort.
- R4: An internal cycle (`cyc_type` 2'b00, and also 2'b11) inserts no wait and produces no memory strobe.
- R5: A non-sequential cycle whose address is above `XLATE_LIMIT` sees exactly one wait cycle. `abort` is 1 in its completing cycle only, and `mem_en` stays 0.
- R6: `nwait_n` changes only while `clk` is low.
- R7: While `lock` is 1 at a boundary, no grant is given. Both accesses of a locked swap run with `ext_gnt` at 0 throughout, even when `ext_req` is already high.
- R8: A pending `ext_req` is granted at the first boundary where `lock` is 0. The grant never appears during the wait cycles of a processor access.
- R9: While `ext_gnt` is 1, a processor memory cycle is held with `nwait_n` at 0. When `ext_req` falls, `ext_gnt` falls at the next edge and the held cycle proceeds.
- R10: `mem_en` is never 1 together with `ext_gnt` or with `abort`.
- R11: Wait has no timeout: a processor cycle stays held for as long as the other master keeps its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_type | input | 2 | Cycle type: 00 internal, 01 sequential, 10 non-sequential, 11 internal |
| addr | input | ADDR_W | Access address |
| wr | input | 1 | 1 for a write access |
| lock | input | 1 | Locked-sequence flag from the processor |
| ext_req | input | 1 | Memory request from the other master |
| nwait_n | output | 1 | Active-low wait, updated on the falling edge |
| abort | output | 1 | Translation fault, one cycle |
| ext_gnt | output | 1 | Memory granted to the other master |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write enable accompanying `mem_en` |
| mem_addr | output | ADDR_W | Address accompanying `mem_en` |

## Verification
A state register stuck in XLATE or STALL would show as a wait count that differs from `N_WAIT`, or as a missing `mem_en` pulse at the next low-phase sample. A wrong boundary decision would show as `ext_gnt` rising during a swap or during a stall. In both cases the symptom appears within the same access. A fault path that misfires shows as `abort` on a sequential cycle, or as an abort lasting longer than one cycle, which is caught on the very next sample. Seeded random cycle mixes cover the dispatch paths. Directed swaps, limit-edge addresses and a long external hold cover the arbitration corners.

// File: rtl/mc_pkg.sv
package mc_pkg;
    typedef enum logic [1:0] {
        CYC_INT  = 2'b00,
        CYC_SEQ  = 2'b01,
        CYC_NSEQ = 2'b10,
        CYC_AUX  = 2'b11
    } cyc_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XLATE = 2'd1,
        ST_STALL = 2'd2,
        ST_EXT   = 2'd3
    } mc_state_e;
endpackage

// File: rtl/mc_xlate.sv
module mc_xlate #(
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] XLATE_LIMIT = 32'h00FF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              fault
);
    localparam logic [ADDR_W-1:0] LIMIT_W = ADDR_W'(XLATE_LIMIT);

    logic [ADDR_W-1:0] addr_q;

    // The address register loads only on a non-sequential dispatch.
    // Between dispatches the translation logic is quiet.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else if (cap)
            addr_q <= addr_in;
    end

    assign fault = (addr_q > LIMIT_W);

    // R3
    xlate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(addr_q));
endmodule

// File: rtl/mc_wait_cnt.sv
module mc_wait_cnt #(
    parameter int N_WAIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output logic done
);
    localparam int CNT_W = (N_WAIT > 2) ? $clog2(N_WAIT) : 1;

    generate
        if (N_WAIT > 1) begin : g_count
            localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(N_WAIT - 2);
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (load)
                    cnt_q <= LOAD_V;
                else if (dec)
                    cnt_q <= cnt_q - 1'b1;
            end

            assign done = (cnt_q == '0);

            // R2
            wait_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
                dec |-> (cnt_q != '0));
            // R2
            wait_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= LOAD_V);
        end else begin : g_none
            logic unused_in;
            assign unused_in = load ^ dec ^ clk ^ rst_n;
            assign done      = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/mc_arb.sv
module mc_arb (
    input  logic boundary,
    input  logic ext_req,
    input  logic lock,
    output logic take_ext
);
    // The other master wins at a boundary unless the processor is locked.
    assign take_ext = boundary & ext_req & ~lock;
endmodule

// File: rtl/lockwait_memctl.sv
module lockwait_memctl #(
    parameter int          ADDR_W      = 32,
    parameter int          N_WAIT      = 2,
    parameter logic [31:0] XLATE_LIMIT = 32'h00FF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cyc_type,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              lock,
    input  logic              ext_req,
    output logic              nwait_n,
    output logic              abort,
    output logic              ext_gnt,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr
);
    import mc_pkg::*;

    localparam bit MULTI_WAIT = (N_WAIT > 1);

    mc_state_e         st_q, st_d;
    logic              hold_q, hold_d;
    logic              en_d, abort_d, gnt_d, we_d;
    logic [ADDR_W-1:0] addr_d;
    logic              cap, cnt_load, cnt_dec, cnt_done, fault, take_ext;
    logic              boundary, is_mem;

    assign boundary = (st_q == ST_IDLE) || (st_q == ST_EXT);
    assign is_mem   = (cyc_type == CYC_SEQ) || (cyc_type == CYC_NSEQ);

    mc_arb u_arb (
        .boundary (boundary),
        .ext_req  (ext_req),
        .lock     (lock),
        .take_ext (take_ext)
    );

    mc_xlate #(
        .ADDR_W      (ADDR_W),
        .XLATE_LIMIT (XLATE_LIMIT)
    ) u_xlate (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (cap),
        .addr_in (addr),
        .fault   (fault)
    );

    mc_wait_cnt #(
        .N_WAIT (N_WAIT)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cnt_load),
        .dec   (cnt_dec),
        .done  (cnt_done)
    );

    // Next-state process
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE, ST_EXT: begin
                if (take_ext)
                    st_d = ST_EXT;                 // GRANT or stay granted
                else if (cyc_type == CYC_NSEQ)
                    st_d = ST_XLATE;               // DISPATCH_N
                else
                    st_d = ST_IDLE;                // DISPATCH_S, RELEASE, internal
            end
            ST_XLATE: begin
                if (fault)
                    st_d = ST_IDLE;                // FAULT
                else if (MULTI_WAIT)
                    st_d = ST_STALL;               // LONG
                else
                    st_d = ST_IDLE;                // SHORT
            end
            ST_STALL: begin
                if (cnt_done)
                    st_d = ST_IDLE;                // FINISH
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Output-decode process
    always_comb begin
        hold_d   = 1'b0;
        en_d     = 1'b0;
        abort_d  = 1'b0;
        gnt_d    = 1'b0;
        we_d     = mem_we;
        addr_d   = mem_addr;
        cap      = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_EXT: begin
                if (take_ext) begin
                    gnt_d  = 1'b1;
                    hold_d = is_mem;
                end else if (cyc_type == CYC_NSEQ) begin
                    hold_d = 1'b1;
                    cap    = 1'b1;
                    we_d   = wr;
                    addr_d = addr;
                end else if (cyc_type == CYC_SEQ) begin
                    en_d   = 1'b1;
                    we_d   = wr;
                    addr_d = addr;
                end
            end
            ST_XLATE: begin
                if (fault) begin
                    abort_d = 1'b1;
                end else if (MULTI_WAIT) begin
                    hold_d   = 1'b1;
                    cnt_load = 1'b1;
                end else begin
                    en_d = 1'b1;
                end
            end
            ST_STALL: begin
                if (cnt_done) begin
                    en_d = 1'b1;
                end else begin
                    hold_d  = 1'b1;
                    cnt_dec = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // State and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            hold_q   <= 1'b0;
            mem_en   <= 1'b0;
            abort    <= 1'b0;
            ext_gnt  <= 1'b0;
            mem_we   <= 1'b0;
            mem_addr <= '0;
        end else begin
            st_q     <= st_d;
            hold_q   <= hold_d;
            mem_en   <= en_d;
            abort    <= abort_d;
            ext_gnt  <= gnt_d;
            mem_we   <= we_d;
            mem_addr <= addr_d;
        end
    end

    // The wait output moves on the falling edge only, which stretches the low phase.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)
            nwait_n <= 1'b1;
        else
            nwait_n <= ~hold_q;
    end

    // R6
    always @(nwait_n) begin
        if (rst_n === 1'b1) begin
            nwait_low_phase_chk: assert (clk == 1'b0);
        end
    end

    // R7
    lock_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> !ext_gnt);

    // R8
    grant_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_gnt) |-> $past(st_q == ST_IDLE));

    // R10
    strobe_vs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_en && ext_gnt));

    // R10
    strobe_vs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_en && abort));

    // R5
    abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort);

    // R5
    abort_after_xlate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> $past(st_q == ST_XLATE));

    // R3
    seq_zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && cyc_type == CYC_SEQ && !take_ext) |=> (mem_en && !hold_q));
endmodule

// File: tb/lockwait_memctl_test.sv
module lockwait_memctl_test;
    localparam int          AW    = 32;
    localparam int          NW    = 2;
    localparam logic [31:0] LIMIT = 32'h00FF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cyc_type = 2'b00;
    logic [AW-1:0] addr = '0;
    logic          wr = 1'b0, lock = 1'b0, ext_req = 1'b0;
    logic          nwait_n, abort, ext_gnt, mem_en, mem_we;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lockwait_memctl #(.ADDR_W(AW), .N_WAIT(NW), .XLATE_LIMIT(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .cyc_type(cyc_type), .addr(addr), .wr(wr),
        .lock(lock), .ext_req(ext_req), .nwait_n(nwait_n), .abort(abort),
        .ext_gnt(ext_gnt), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_waits(input logic [1:0] c, input logic [AW-1:0] a);
        if (c == 2'b10) return (a > LIMIT) ? 1 : NW;
        return 0;
    endfunction

    function automatic bit exp_en(input logic [1:0] c, input logic [AW-1:0] a);
        return (c == 2'b01) || (c == 2'b10 && a <= LIMIT);
    endfunction

    function automatic bit exp_abort(input logic [1:0] c, input logic [AW-1:0] a);
        return (c == 2'b10) && (a > LIMIT);
    endfunction

    // Move to 1 ns before the next rising edge.
    task automatic to_sample();
        @(negedge clk);
        #4;
    endtask

    // Present one cycle at the sample point, then follow it to completion.
    task automatic acc(input logic [1:0] c, input logic [AW-1:0] a, input logic w,
                       input logic lk, input bit raise);
        int  waits = 0;
        bit  done  = 0;
        string tag;
        tag = (c == 2'b10) ? ((a > LIMIT) ? "R5" : "R2") : ((c == 2'b01) ? "R3" : "R4");
        cyc_type = c; addr = a; wr = w; lock = lk;
        @(posedge clk);
        while (!done) begin
            to_sample();
            if (nwait_n == 1'b0) begin
                waits++;
                chk(mem_en == 1'b0, tag, "strobe during wait", mem_en, 0);
                chk(ext_gnt == 1'b0, lk ? "R7" : "R8", "grant during access", ext_gnt, 0);
                if (raise && waits == 1) ext_req = 1'b1;
                @(posedge clk);
            end else begin
                done = 1;
            end
        end
        chk(waits == exp_waits(c, a), tag, "wait count", waits, exp_waits(c, a));
        chk(mem_en == exp_en(c, a), tag, "mem_en", mem_en, exp_en(c, a));
        chk(abort == exp_abort(c, a), tag, "abort", abort, exp_abort(c, a));
        chk(ext_gnt == 1'b0, "R10", "grant at completion", ext_gnt, 0);
        if (exp_en(c, a)) begin
            chk(mem_we == w, tag, "mem_we", mem_we, w);
            chk(mem_addr == a, tag, "mem_addr", mem_addr, a);
        end
    endtask

    task automatic idle_cycle();
        cyc_type = 2'b00; lock = 1'b0;
        @(posedge clk);
        to_sample();
    endtask

    initial begin
        #(100000 * 10);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd4051);
        // R1 reset state
        repeat (3) to_sample();
        chk(nwait_n == 1'b1, "R1", "nwait_n", nwait_n, 1);
        chk(abort == 1'b0, "R1", "abort", abort, 0);
        chk(ext_gnt == 1'b0, "R1", "ext_gnt", ext_gnt, 0);
        chk(mem_en == 1'b0, "R1", "mem_en", mem_en, 0);
        rst_n = 1'b1;
        idle_cycle();
        chk(nwait_n == 1'b1 && mem_en == 1'b0, "R1", "after release", {nwait_n, mem_en}, 2'b10);

        // Limit-edge directed cases (R2, R5, R3)
        acc(2'b10, LIMIT, 1'b1, 1'b0, 1'b0);
        acc(2'b10, LIMIT + 1, 1'b0, 1'b0, 1'b0);
        acc(2'b01, LIMIT + 5, 1'b1, 1'b0, 1'b0);
        acc(2'b11, 32'h10, 1'b0, 1'b0, 1'b0);
        // R5: abort cleared in the next cycle
        acc(2'b10, 32'hFFFF_0000, 1'b0, 1'b0, 1'b0);
        idle_cycle();
        chk(abort == 1'b0, "R5", "abort one cycle", abort, 0);

        // R7: locked swap with a pending request, then R8 grant at the boundary
        ext_req = 1'b1;
        acc(2'b10, 32'h0000_4000, 1'b0, 1'b1, 1'b0);
        acc(2'b10, 32'h0000_4000, 1'b1, 1'b1, 1'b0);
        chk(ext_gnt == 1'b0, "R7", "grant before unlock", ext_gnt, 0);
        idle_cycle();
        chk(ext_gnt == 1'b1, "R8", "grant after unlock", ext_gnt, 1);

        // R9, R11: sequential cycle held through a long grant
        begin
            int waits = 0;
            int hold_len = 50;
            cyc_type = 2'b01; addr = 32'h0000_0100; wr = 1'b1; lock = 1'b0;
            @(posedge clk);
            to_sample();
            while (nwait_n == 1'b0 && waits < 1000) begin
                waits++;
                chk(ext_gnt == 1'b1 && mem_en == 1'b0, "R9", "held under grant",
                    {ext_gnt, mem_en}, 2'b10);
                if (waits == hold_len) ext_req = 1'b0;
                @(posedge clk);
                to_sample();
            end
            chk(waits == hold_len, "R11", "held wait count", waits, hold_len);
            chk(ext_gnt == 1'b0, "R9", "grant released", ext_gnt, 0);
            chk(mem_en == 1'b1 && mem_addr == 32'h0000_0100, "R9", "held access done",
                mem_en, 1);
        end

        // R8: request raised during a stall waits for the boundary
        acc(2'b10, 32'h0000_0200, 1'b0, 1'b0, 1'b1);
        idle_cycle();
        chk(ext_gnt == 1'b1, "R8", "grant after access", ext_gnt, 1);
        ext_req = 1'b0;
        idle_cycle();
        chk(ext_gnt == 1'b0, "R9", "grant dropped", ext_gnt, 0);

        // Random mix of cycle types and addresses (R2, R3, R4, R5)
        for (int i = 0; i < 300; i++) begin
            logic [1:0]    c;
            logic [AW-1:0] a;
            c = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 0)
                a = AW'($urandom_range(0, 32'h00FF_FFFF));
            else
                a = LIMIT + 1 + AW'($urandom_range(0, 4000));
            acc(c, a, 1'($urandom_range(0, 1)), 1'b0, 1'b0);
        end
        idle_cycle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule